// File: doc/BRIEF.md
# Halfword Multiply-Accumulate-Long Unit

This block decodes and executes one instruction: a signed 16x16 multiply whose 32-bit product is sign-extended and added into a 64-bit accumulator. The accumulator is held as a pair of 32-bit registers. The instruction word arrives on a valid/ready issue port, and an input flag says which of two encodings it uses. Two register fields name the multiplier sources. Two more fields name the low and high accumulator words. Two select bits choose the top or bottom halfword of each source. A small internal 16 x 32-bit register file supplies all four operands and receives both result words in one writeback.

The condition-carrying encoding executes only when the external condition-pass input is high. A word that breaks the fixed bits of its encoding produces a one-cycle illegal pulse instead of a completion. A test write port preloads registers, and a combinational read port observes them.

Top module: `hmal_unit`

## Requirements
- R1: Operand halfword select: a select bit of 1 takes bits [31:16] of its source and 0 takes bits [15:0]. The unselected half has no effect on the result. N selects for the Rn source and M selects for the Rm source.
- R2: The result is {RdHi,RdLo} + sign_extend64(signed(half_n) * signed(half_m)). The upper 32 bits are written to RdHi and the lower 32 bits to RdLo.
- R3: The 64-bit addition wraps modulo 2^64. There is no overflow indication of any kind.
- R4: With enc_sel_i=0 (encoding A), the fields are:
  - cond [31:28];
  - fixed [27:20]=8'h14;
  - RdHi [19:16], RdLo [15:12], Rm [11:8];
  - fixed bit7=1;
  - M select bit6, N select bit5;
  - fixed bit4=0;
  - Rn [3:0].
- R5: With enc_sel_i=1 (encoding B), the fields are:
  - fixed [31:20]=12'hFBC;
  - Rn [19:16], RdLo [15:12], RdHi [11:8];
  - fixed [7:6]=2'b10;
  - N select bit5, M select bit4;
  - Rm [3:0].
  
  cond_pass_i has no effect on encoding B.
- R6: If a fixed bit mismatches, or encoding A carries cond 4'b1111, illegal_o is high for exactly the cycle after acceptance. In that case done_o stays low and no register changes.
- R7: In encoding A with cond_pass_i low at acceptance, done_o still pulses but no register changes.
- R8: When RdHi equals RdLo, that register receives the high result word, and the unit keeps accepting issues.
- R9: done_o is high in the cycle after acceptance. Register contents change at the following edge. An instruction accepted in the cycle done_o is high already sees the pending results.
- R10: issue_ready_o is low while tw_en_i is high. A test write updates its register at the next edge. rd_data_o shows register rd_addr_i combinationally. A writeback on the same edge as a test write to the same register wins.
- R11: After reset done_o and illegal_o are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | Instruction word offered |
| issue_ready_o | output | 1 | Unit accepts an instruction this cycle |
| instr_i | input | 32 | Instruction word |
| enc_sel_i | input | 1 | 0 = encoding A, 1 = encoding B |
| cond_pass_i | input | 1 | Condition result for encoding A |
| done_o | output | 1 | Legal instruction completed |
| illegal_o | output | 1 | Instruction rejected |
| tw_en_i | input | 1 | Test write enable |
| tw_addr_i | input | 4 | Test write register |
| tw_data_i | input | 32 | Test write data |
| rd_addr_i | input | 4 | Observation register |
| rd_data_o | output | 32 | Observation data |

## Verification
A wrong half select, a swapped field or a bad sign extension corrupts RdHi or RdLo. It appears on the read port two edges after acceptance, when every register is compared with the reference. A broken forwarding path appears only when the next instruction is accepted in the done cycle: the second result then uses stale accumulator words, so back-to-back chains are driven on purpose. A wrongly gated write enable shows as a changed register after an illegal or condition-failed issue, caught at the same two-edge point.

// File: rtl/hmal_pkg.sv
package hmal_pkg;
  localparam int REG_AW = 4;

  typedef enum logic {ENC_A = 1'b0, ENC_B = 1'b1} enc_e;

  typedef struct packed {
    logic              legal;
    logic              cond_gated;
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rm;
    logic [REG_AW-1:0] rdlo;
    logic [REG_AW-1:0] rdhi;
    logic              nsel;
    logic              msel;
  } dec_t;
endpackage

// File: rtl/hmal_decoder.sv
module hmal_decoder
  import hmal_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        enc_sel_i,
  output dec_t        dec_o
);
  dec_t dec_a, dec_b;

  always_comb begin
    dec_a.legal      = (instr_i[31:28] != 4'hF) && (instr_i[27:20] == 8'h14) &&
                       instr_i[7] && !instr_i[4];
    dec_a.cond_gated = 1'b1;
    dec_a.rdhi       = instr_i[19:16];
    dec_a.rdlo       = instr_i[15:12];
    dec_a.rm         = instr_i[11:8];
    dec_a.msel       = instr_i[6];
    dec_a.nsel       = instr_i[5];
    dec_a.rn         = instr_i[3:0];
  end

  always_comb begin
    dec_b.legal      = (instr_i[31:20] == 12'hFBC) && (instr_i[7:6] == 2'b10);
    dec_b.cond_gated = 1'b0;
    dec_b.rn         = instr_i[19:16];
    dec_b.rdlo       = instr_i[15:12];
    dec_b.rdhi       = instr_i[11:8];
    dec_b.nsel       = instr_i[5];
    dec_b.msel       = instr_i[4];
    dec_b.rm         = instr_i[3:0];
  end

  assign dec_o = (enc_e'(enc_sel_i) == ENC_B) ? dec_b : dec_a;
endmodule

// File: rtl/hmal_regfile.sv
module hmal_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NRD   = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tw_en_i,
  input  logic [AW-1:0]          tw_addr_i,
  input  logic [DW-1:0]          tw_data_i,
  input  logic                   wb_en_i,
  input  logic [AW-1:0]          wb_lo_addr_i,
  input  logic [DW-1:0]          wb_lo_data_i,
  input  logic [AW-1:0]          wb_hi_addr_i,
  input  logic [DW-1:0]          wb_hi_data_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    // later assignments win: test write < low word < high word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else begin
        if (tw_en_i && tw_addr_i == AW'(g)) mem[g] <= tw_data_i;
        if (wb_en_i && wb_lo_addr_i == AW'(g)) mem[g] <= wb_lo_data_i;
        if (wb_en_i && wb_hi_addr_i == AW'(g)) mem[g] <= wb_hi_data_i;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/hmal_mac.sv
module hmal_mac #(
  parameter int HW  = 16,
  localparam int DW = 2 * HW,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] op_n_i,
  input  logic [DW-1:0] op_m_i,
  input  logic          nsel_i,
  input  logic          msel_i,
  input  logic [DW-1:0] acc_hi_i,
  input  logic [DW-1:0] acc_lo_i,
  output logic [DW-1:0] res_hi_o,
  output logic [DW-1:0] res_lo_o
);
  logic signed [HW-1:0] half_n, half_m;
  logic signed [DW-1:0] prod;
  logic        [AW-1:0] sum;

  assign half_n = nsel_i ? op_n_i[DW-1:HW] : op_n_i[HW-1:0];
  assign half_m = msel_i ? op_m_i[DW-1:HW] : op_m_i[HW-1:0];
  assign prod   = DW'(half_n * half_m);
  assign sum    = {acc_hi_i, acc_lo_i} + {{DW{prod[DW-1]}}, prod};  // wraps mod 2^AW
  assign res_hi_o = sum[AW-1:DW];
  assign res_lo_o = sum[DW-1:0];
endmodule

// File: rtl/hmal_unit.sv
module hmal_unit
  import hmal_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [31:0]       instr_i,
  input  logic              enc_sel_i,
  input  logic              cond_pass_i,
  output logic              done_o,
  output logic              illegal_o,
  input  logic              tw_en_i,
  input  logic [REG_AW-1:0] tw_addr_i,
  input  logic [DW-1:0]     tw_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam int NRD   = 5;
  localparam int P_RN  = 0;
  localparam int P_RM  = 1;
  localparam int P_LO  = 2;
  localparam int P_HI  = 3;
  localparam int P_DBG = 4;

  dec_t dec;
  logic accept, exec_ok;
  logic [NRD-1:0][REG_AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0]     rdata;
  logic [DW-1:0] op_n, op_m, acc_hi, acc_lo, res_hi, res_lo;

  logic              done_q, ill_q, wb_en_q;
  logic [REG_AW-1:0] wb_hi_addr_q, wb_lo_addr_q;
  logic [DW-1:0]     wb_hi_data_q, wb_lo_data_q;

  hmal_decoder u_dec (
    .instr_i   (instr_i),
    .enc_sel_i (enc_sel_i),
    .dec_o     (dec)
  );

  assign raddr = {rd_addr_i, dec.rdhi, dec.rdlo, dec.rm, dec.rn};

  hmal_regfile #(.DW(DW), .DEPTH(NREGS), .NRD(NRD)) u_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tw_en_i      (tw_en_i),
    .tw_addr_i    (tw_addr_i),
    .tw_data_i    (tw_data_i),
    .wb_en_i      (wb_en_q),
    .wb_lo_addr_i (wb_lo_addr_q),
    .wb_lo_data_i (wb_lo_data_q),
    .wb_hi_addr_i (wb_hi_addr_q),
    .wb_hi_data_i (wb_hi_data_q),
    .raddr_i      (raddr),
    .rdata_o      (rdata)
  );

  // bypass of the pending writeback; high word has priority as in the file
  function automatic logic [DW-1:0] fwd(input logic [REG_AW-1:0] a, input logic [DW-1:0] raw);
    if (wb_en_q && a == wb_hi_addr_q)      return wb_hi_data_q;
    else if (wb_en_q && a == wb_lo_addr_q) return wb_lo_data_q;
    else                                   return raw;
  endfunction

  assign op_n   = fwd(dec.rn,   rdata[P_RN]);
  assign op_m   = fwd(dec.rm,   rdata[P_RM]);
  assign acc_lo = fwd(dec.rdlo, rdata[P_LO]);
  assign acc_hi = fwd(dec.rdhi, rdata[P_HI]);

  hmal_mac #(.HW(DW / 2)) u_mac (
    .op_n_i   (op_n),
    .op_m_i   (op_m),
    .nsel_i   (dec.nsel),
    .msel_i   (dec.msel),
    .acc_hi_i (acc_hi),
    .acc_lo_i (acc_lo),
    .res_hi_o (res_hi),
    .res_lo_o (res_lo)
  );

  assign issue_ready_o = !tw_en_i;
  assign accept        = issue_valid_i && issue_ready_o;
  assign exec_ok       = dec.legal && (!dec.cond_gated || cond_pass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q       <= 1'b0;
      ill_q        <= 1'b0;
      wb_en_q      <= 1'b0;
      wb_hi_addr_q <= '0;
      wb_lo_addr_q <= '0;
      wb_hi_data_q <= '0;
      wb_lo_data_q <= '0;
    end else begin
      done_q  <= accept && dec.legal;
      ill_q   <= accept && !dec.legal;
      wb_en_q <= accept && exec_ok;
      if (accept && exec_ok) begin
        wb_hi_addr_q <= dec.rdhi;
        wb_lo_addr_q <= dec.rdlo;
        wb_hi_data_q <= res_hi;
        wb_lo_data_q <= res_lo;
      end
    end
  end

  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign rd_data_o = rdata[P_DBG];
endmodule

// File: rtl/hmal_unit_chk.sv
module hmal_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic issue_valid_i,
  input logic issue_ready_o,
  input logic enc_sel_i,
  input logic cond_pass_i,
  input logic tw_en_i,
  input logic done_o,
  input logic illegal_o,
  input logic wb_en_q
);
  p_done_follows_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(issue_valid_i && issue_ready_o));

  p_illegal_follows_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(issue_valid_i && issue_ready_o));

  p_done_xor_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  p_illegal_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_q);

  p_write_implies_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_q |-> done_o);

  p_cond_fail_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && !enc_sel_i && !cond_pass_i) |=> !wb_en_q);

  p_test_write_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_en_i |-> !issue_ready_o);
endmodule

bind hmal_unit hmal_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_ready_o (issue_ready_o),
  .enc_sel_i     (enc_sel_i),
  .cond_pass_i   (cond_pass_i),
  .tw_en_i       (tw_en_i),
  .done_o        (done_o),
  .illegal_o     (illegal_o),
  .wb_en_q       (wb_en_q)
);

// File: tb/hmal_unit_test.sv
module hmal_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic        issue_ready_o;
  logic [31:0] instr_i = '0;
  logic        enc_sel_i = 1'b0;
  logic        cond_pass_i = 1'b1;
  logic        done_o, illegal_o;
  logic        tw_en_i = 1'b0;
  logic [3:0]  tw_addr_i = '0;
  logic [31:0] tw_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk;

  hmal_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i), .issue_ready_o(issue_ready_o),
    .instr_i(instr_i), .enc_sel_i(enc_sel_i), .cond_pass_i(cond_pass_i), .done_o(done_o),
    .illegal_o(illegal_o), .tw_en_i(tw_en_i), .tw_addr_i(tw_addr_i), .tw_data_i(tw_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr_i = 4'(i);
      #1;
      chk(tag, 64'(rd_data_o), 64'(model[i]));
    end
  endtask

  function automatic logic [31:0] enc_a(input logic [3:0] c, input logic [3:0] hi, lo, rm, rn,
                                        input logic ns, ms);
    return {c, 8'h14, hi, lo, rm, 1'b1, ms, ns, 1'b0, rn};
  endfunction

  function automatic logic [31:0] enc_b(input logic [3:0] hi, lo, rm, rn, input logic ns, ms);
    return {12'hFBC, rn, lo, hi, 2'b10, ns, ms, rm};
  endfunction

  // behavioural reference of one instruction
  task automatic ref_exec(input logic [31:0] w, input bit enc, input bit cp,
                          output bit legal, output bit wr, output int hi_idx);
    int rn, rm, lo, hi;
    bit ns, ms;
    shortint a, b;
    longint acc;
    if (!enc) begin
      legal = (w[31:28] != 4'hF) && (w[27:20] == 8'h14) && w[7] && !w[4];
      hi = int'(w[19:16]); lo = int'(w[15:12]); rm = int'(w[11:8]);
      ms = w[6]; ns = w[5]; rn = int'(w[3:0]);
      wr = legal && cp;
    end else begin
      legal = (w[31:20] == 12'hFBC) && (w[7:6] == 2'b10);
      rn = int'(w[19:16]); lo = int'(w[15:12]); hi = int'(w[11:8]);
      ns = w[5]; ms = w[4]; rm = int'(w[3:0]);
      wr = legal;
    end
    hi_idx = hi;
    if (wr) begin
      a = shortint'(ns ? model[rn][31:16] : model[rn][15:0]);
      b = shortint'(ms ? model[rm][31:16] : model[rm][15:0]);
      acc = longint'({model[hi], model[lo]});
      acc = acc + longint'(int'(a) * int'(b));
      model[lo] = acc[31:0];
      model[hi] = acc[63:32];
    end
  endtask

  task automatic preload(input int a, input logic [31:0] d);
    @(negedge clk);
    tw_en_i = 1'b1; tw_addr_i = 4'(a); tw_data_i = d;
    #1 chk("R10 ready low in test write", 64'(issue_ready_o), 64'd0);
    @(posedge clk);
    @(negedge clk);
    tw_en_i = 1'b0;
    model[a] = d;
    rd_addr_i = 4'(a);
    #1 chk("R10 test write visible", 64'(rd_data_o), 64'(d));
  endtask

  task automatic run_op(input logic [31:0] w, input bit enc, input bit cp, input string tag);
    bit legal, wr;
    int hi;
    logic [31:0] old_hi;
    @(negedge clk);
    issue_valid_i = 1'b1; instr_i = w; enc_sel_i = enc; cond_pass_i = cp;
    @(posedge clk);
    @(negedge clk);
    issue_valid_i = 1'b0;
    ref_exec(w, enc, cp, legal, wr, hi);
    chk({tag, " done"}, 64'(done_o), 64'(legal));
    chk({tag, " illegal"}, 64'(illegal_o), 64'(!legal));
    if (wr) begin
      old_hi = model[hi];  // model already updated; register must still hold pre-write value
      rd_addr_i = 4'(hi);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 pulse ends"}, 64'(done_o | illegal_o), 64'd0);
    chk_regs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit legal, wr;
    int hi;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    chk("R11 done low", 64'(done_o), 64'd0);
    chk("R11 illegal low", 64'(illegal_o), 64'd0);
    chk("R11 ready", 64'(issue_ready_o), 64'd1);
    chk_regs("R11 regs zero");

    preload(1, 32'h7FFF_8000);
    preload(2, 32'h8000_0003);
    preload(4, 32'h0000_0010);
    preload(5, 32'h0000_0001);

    // R1 R2 R4: four half-select variants, encoding A
    run_op(enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b0, 1'b0), 1'b0, 1'b1, "R1 R4 bb");
    run_op(enc_a(4'hE, 4'd5, 4'd4, 4'd2, 4'd1, 1'b0, 1'b1), 1'b0, 1'b1, "R1 R4 bt");
    run_op(enc_a(4'h3, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b0), 1'b0, 1'b1, "R1 R4 tb");
    run_op(enc_a(4'h7, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1), 1'b0, 1'b1, "R2 R4 tt");

    // R1 unselected half ignored: only top halves differ, bottom x bottom
    preload(6, 32'h1234_0005); preload(7, 32'hABCD_FFFE);
    preload(8, 32'h0); preload(9, 32'h0);
    run_op(enc_a(4'h0, 4'd9, 4'd8, 4'd7, 4'd6, 1'b0, 1'b0), 1'b0, 1'b1, "R1 ignore top");
    chk("R1 product lo", 64'(model[8]), 64'hFFFF_FFF6);

    // R5: encoding B, cond_pass ignored
    run_op(enc_b(4'd9, 4'd8, 4'd2, 4'd1, 1'b1, 1'b0), 1'b1, 1'b0, "R5 encB tb");
    run_op(enc_b(4'd9, 4'd8, 4'd1, 4'd2, 1'b0, 1'b1), 1'b1, 1'b1, "R5 encB bt");

    // R3 wrap modulo 2^64
    preload(10, 32'hFFFF_FFFF); preload(11, 32'hFFFF_FFFF);
    preload(12, 32'h0002_0003);
    run_op(enc_a(4'h0, 4'd11, 4'd10, 4'd12, 4'd12, 1'b1, 1'b0), 1'b0, 1'b1, "R3 wrap");
    chk("R3 wrapped lo", 64'(model[10]), 64'h5);
    preload(10, 32'hFFFF_FFFF); preload(11, 32'h7FFF_FFFF);
    run_op(enc_b(4'd11, 4'd10, 4'd12, 4'd12, 1'b1, 1'b1), 1'b1, 1'b1, "R3 signed overflow");

    // R7 condition fail
    run_op(enc_a(4'h1, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1), 1'b0, 1'b0, "R7 cond fail");

    // R6 illegal words
    run_op(enc_a(4'hF, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1), 1'b0, 1'b1, "R6 cond 1111");
    run_op(enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1) ^ 32'h0000_0010, 1'b0, 1'b1, "R6 A bit4");
    run_op(enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1) ^ 32'h0010_0000, 1'b0, 1'b1, "R6 A opcode");
    run_op(enc_b(4'd5, 4'd4, 4'd2, 4'd1, 1'b0, 1'b0) ^ 32'h0000_0080, 1'b1, 1'b1, "R6 B bits76");
    run_op(enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b0, 1'b0), 1'b1, 1'b1, "R6 wrong enc");

    // R8 RdHi == RdLo
    preload(13, 32'h0000_0100);
    run_op(enc_a(4'h0, 4'd13, 4'd13, 4'd2, 4'd1, 1'b0, 1'b0), 1'b0, 1'b1, "R8 same reg");
    run_op(enc_b(4'd13, 4'd13, 4'd2, 4'd1, 1'b1, 1'b1), 1'b1, 1'b1, "R8 still accepts");

    // R9 back-to-back: second reads first result through forwarding
    @(negedge clk);
    issue_valid_i = 1'b1; enc_sel_i = 1'b0; cond_pass_i = 1'b1;
    instr_i = enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    ref_exec(instr_i, 1'b0, 1'b1, legal, wr, hi);
    chk("R9 b2b first done", 64'(done_o), 64'd1);
    instr_i = enc_a(4'h0, 4'd5, 4'd4, 4'd5, 4'd4, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    ref_exec(instr_i, 1'b0, 1'b1, legal, wr, hi);
    issue_valid_i = 1'b0;
    chk("R9 b2b second done", 64'(done_o), 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk_regs("R9 b2b regs");

    // R10 issue blocked during test write
    @(negedge clk);
    tw_en_i = 1'b1; tw_addr_i = 4'd14; tw_data_i = 32'hCAFE_0001;
    issue_valid_i = 1'b1; instr_i = enc_a(4'h0, 4'd5, 4'd4, 4'd2, 4'd1, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    tw_en_i = 1'b0; issue_valid_i = 1'b0;
    model[14] = 32'hCAFE_0001;
    chk("R10 blocked no done", 64'(done_o), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk_regs("R10 blocked regs");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule